// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Change Interrupts

This block is a general-purpose I/O port of up to 32 lines, reached through a simple 32-bit register bus. Software selects each line as an input or an output and sets the level driven on output lines. A data read returns the level seen at every pin, including lines the port drives. All pins pass through a two-flop synchroniser before any other logic uses them.

Any rising or falling transition on a synchronised pin sets a sticky change bit. Software acknowledges a change bit by writing a one to it. A per-line enable selects which change bits drive one shared, level-sensitive interrupt output. A write-mask register selects the data bits that a data write may modify. This lets several agents change separate lines without a read-modify-write sequence.

Top module: `gpio_port`

## Requirements
- R1: After reset, all lines are inputs (`pad_oe` all 0), the output data is 0, the enable and change registers are 0, `irq` is low, and the write mask reads back as ones on every implemented line.
- R2: The direction register is at byte offset 0x00. A bit value of 1 makes that line an output, so `pad_oe` goes high and `pad_out` carries the line's output-data bit. A bit value of 0 releases the line. The register keeps its value until it is written.
- R3: A read at offset 0x04 returns each line's pin level. A level applied at `pad_in` becomes visible in the read after two rising clock edges.
- R4: A write at offset 0x04 changes only the output-data bits whose write-mask bit is 1. The write mask is at offset 0x10 and can be read back.
- R5: Each rising or falling transition of a synchronised pin sets that line's bit in the change register at offset 0x0C. The bit is set three rising edges after the pin changes.
- R6: Writing 1 to a change bit clears it. Writing 0 leaves it unchanged.
- R7: A clear and a new transition may land on the same bit in the same cycle. In that case the change bit stays set.
- R8: The interrupt-enable register is at offset 0x08. `irq` is high exactly while some line has both its change bit and its enable bit at 1.
- R9: The number of implemented lines is the parameter `LINES`, at most 32. In every register, bits at or above `LINES` read as 0, and writes to them are ignored.
- R10: The trigger-type register at offset 0x14 reads 1 (meaning both-edge) on each implemented line. Writes to it are ignored.
- R11: Reads of any other offset, and reads at an address that is not word-aligned, return 0. `bus_rdata` is 0 while `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | LINES | Level present at each pin |
| pad_out | output | LINES | Value driven on lines configured as outputs |
| pad_oe | output | LINES | Output enable per line |
| irq | output | 1 | Shared level-sensitive interrupt |

## Verification
The change-register assertions assume that a pin transition reaches the edge detector only through the synchroniser. They also treat a one-cycle edge pulse and a clear strobe as independent events, so both may occur in any cycle.

The bench changes pin levels only at falling clock edges and holds each level for several cycles. Every transition therefore produces exactly one detected edge. The single case where a clear must meet an edge in the same cycle is arranged by counting the three synchroniser edges explicitly.

The output-enable loopback is modelled outside the block. Driven lines return their own output value to `pad_in`, and the bench accounts for those edges in its expected change bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int WORD_W = 32;

  // register offsets (byte addresses, software-visible map)
  localparam logic [7:0] OFF_DIR  = 8'h00;
  localparam logic [7:0] OFF_DATA = 8'h04;
  localparam logic [7:0] OFF_IEN  = 8'h08;
  localparam logic [7:0] OFF_CHG  = 8'h0C;
  localparam logic [7:0] OFF_MASK = 8'h10;
  localparam logic [7:0] OFF_TYPE = 8'h14;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_DATA,
    SEL_IEN,
    SEL_CHG,
    SEL_MASK,
    SEL_TYPE,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [7:0] a);
    reg_sel_e s;
    case (a)
      OFF_DIR:  s = SEL_DIR;
      OFF_DATA: s = SEL_DATA;
      OFF_IEN:  s = SEL_IEN;
      OFF_CHG:  s = SEL_CHG;
      OFF_MASK: s = SEL_MASK;
      OFF_TYPE: s = SEL_TYPE;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] edge_o
);

  logic [LINES-1:0] meta_q;
  logic [LINES-1:0] sync_q;
  logic [LINES-1:0] prev_q;

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q[i] <= 1'b0;
          sync_q[i] <= 1'b0;
          prev_q[i] <= 1'b0;
        end else begin
          meta_q[i] <= pad_i[i];
          sync_q[i] <= meta_q[i];
          prev_q[i] <= sync_q[i];
        end
      end
    end
  endgenerate

  assign level_o = sync_q;
  assign edge_o  = sync_q ^ prev_q;

endmodule

// File: rtl/gpio_chg_latch.sv
module gpio_chg_latch #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] edge_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] chg_o
);

  logic [LINES-1:0] chg_q;
  logic [LINES-1:0] chg_n;

  // an edge in the clearing cycle wins so no event is dropped
  always_comb begin
    chg_n = (chg_q & ~clr_i) | edge_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= chg_n;
  end

  assign chg_o = chg_q;

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_chk
      assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i[i] |=> chg_q[i]);
      assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !edge_i[i]) |=> !chg_q[i]);
      assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_q[i] && !clr_i[i]) |=> chg_q[i]);
      assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && edge_i[i]) |=> chg_q[i]);
    end
  endgenerate

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic              irq
);

  localparam logic [LINES-1:0] TYPE_BOTH = '1;
  localparam logic [LINES-1:0] MASK_INIT = '1;

  logic             rst_n_s;
  reg_sel_e         sel;
  logic             wr_en;
  logic             we_dir, we_data, we_ien, we_chg, we_mask;
  logic [LINES-1:0] wdata_l;
  logic [LINES-1:0] level;
  logic [LINES-1:0] edge_det;
  logic [LINES-1:0] chg;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] rd_l;
  logic             unused_wdata;

  logic [LINES-1:0] dir_q,  dir_n;
  logic [LINES-1:0] out_q,  out_n;
  logic [LINES-1:0] ien_q,  ien_n;
  logic [LINES-1:0] mask_q, mask_n;

  gpio_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  gpio_pin_sync #(.LINES(LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pad_i   (pad_in),
    .level_o (level),
    .edge_o  (edge_det)
  );

  gpio_chg_latch #(.LINES(LINES)) u_chg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .edge_i (edge_det),
    .clr_i  (clr),
    .chg_o  (chg)
  );

  // address decode and write strobes
  always_comb begin
    sel     = decode_addr(8'(bus_addr));
    wr_en   = bus_sel && bus_wr;
    wdata_l = bus_wdata[LINES-1:0];
    we_dir  = wr_en && (sel == SEL_DIR);
    we_data = wr_en && (sel == SEL_DATA);
    we_ien  = wr_en && (sel == SEL_IEN);
    we_chg  = wr_en && (sel == SEL_CHG);
    we_mask = wr_en && (sel == SEL_MASK);
  end

  assign unused_wdata = ^bus_wdata;

  // next-state
  always_comb begin
    dir_n  = dir_q;
    out_n  = out_q;
    ien_n  = ien_q;
    mask_n = mask_q;
    if (we_dir)  dir_n  = wdata_l;
    if (we_data) out_n  = (out_q & ~mask_q) | (wdata_l & mask_q);
    if (we_ien)  ien_n  = wdata_l;
    if (we_mask) mask_n = wdata_l;
    clr = we_chg ? wdata_l : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      mask_q <= MASK_INIT;
    end else begin
      dir_q  <= dir_n;
      out_q  <= out_n;
      ien_q  <= ien_n;
      mask_q <= mask_n;
    end
  end

  // read path
  always_comb begin
    case (sel)
      SEL_DIR:  rd_l = dir_q;
      SEL_DATA: rd_l = level;
      SEL_IEN:  rd_l = ien_q;
      SEL_CHG:  rd_l = chg;
      SEL_MASK: rd_l = mask_q;
      SEL_TYPE: rd_l = TYPE_BOTH;
      default:  rd_l = '0;
    endcase
  end

  assign bus_rdata = bus_sel ? WORD_W'(rd_l) : '0;
  assign pad_out   = out_q;
  assign pad_oe    = dir_q;
  assign irq       = |(chg & ien_q);

  assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    we_data |=> (((out_q ^ $past(out_q)) & ~$past(mask_q)) == '0));
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !we_data |=> $stable(out_q));
  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !we_dir |=> $stable(dir_q));
  assert_ien_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !we_ien |=> $stable(ien_q));

endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;

  localparam int NL = 4;
  localparam logic [31:0] FULL = 32'h0000_000F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] pad_in, pad_out, pad_oe, ext = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port #(.LINES(NL), .ADDR_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  // caller stands at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[4:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[4:0];
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [NL-1:0] acc, prev, outm;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk(32'(pad_oe), 0, "R1 pad_oe");
    chk(32'(pad_out), 0, "R1 pad_out");
    chk(32'(irq), 0, "R1 irq");
    rd(8'h00, v); chk(v, 0, "R1 dir");
    rd(8'h08, v); chk(v, 0, "R1 ien");
    rd(8'h0C, v); chk(v, 0, "R1 chg");
    rd(8'h10, v); chk(v, FULL, "R1 mask");

    // R10 type register constant, writes ignored
    rd(8'h14, v); chk(v, FULL, "R10 type");
    @(negedge clk); wr(8'h14, 32'h0); rd(8'h14, v); chk(v, FULL, "R10 type after write");

    // R11 unmapped and misaligned reads, deselected bus
    rd(8'h18, v); chk(v, 0, "R11 unmapped");
    rd(8'h05, v); chk(v, 0, "R11 misaligned");
    bus_addr = 5'h10; #1 chk(bus_rdata, 0, "R11 bus_sel low");

    // R2 / R9 direction sweep with upper bits set
    for (int d = 0; d < 16; d++) begin
      @(negedge clk); wr(8'h00, 32'hFFFF_FFF0 | 32'(d));
      rd(8'h00, v); chk(v, 32'(d), "R9 dir readback");
      chk(32'(pad_oe), 32'(d), "R2 pad_oe");
    end
    @(negedge clk); wr(8'h00, 32'h0);
    idle(4);
    @(negedge clk); wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk(v, 0, "R6 clear all");

    // R3 / R5 input sweep
    acc = '0; prev = ext;
    for (int p = 0; p < 16; p++) begin
      int q;
      q = (p * 7 + 3) % 16;
      @(negedge clk); ext = q[NL-1:0];
      idle(1);
      rd(8'h04, v); chk(v, 32'(prev), "R3 level after one edge");
      idle(1);
      rd(8'h04, v); chk(v, 32'(q), "R3 level after two edges");
      idle(2);
      acc = acc | (prev ^ q[NL-1:0]);
      prev = q[NL-1:0];
      rd(8'h0C, v); chk(v, 32'(acc), "R5 change accumulate");
    end
    @(negedge clk); wr(8'h0C, 32'hFFFF_FFFF);

    // R6 partial clear
    @(negedge clk); ext = ~ext; idle(4);
    rd(8'h0C, v); chk(v, FULL, "R5 all toggled");
    @(negedge clk); wr(8'h0C, 32'h5);
    rd(8'h0C, v); chk(v, 32'hA, "R6 partial clear");
    @(negedge clk); wr(8'h0C, 32'h0);
    rd(8'h0C, v); chk(v, 32'hA, "R6 zero write keeps");
    @(negedge clk); wr(8'h0C, 32'hFFFF_FFFF);

    // R7 edge coincides with clear: bit 1 already set, toggle again
    @(negedge clk); ext[1] = ~ext[1]; idle(4);
    rd(8'h0C, v); chk(v, 32'h2, "R7 preset");
    @(negedge clk); ext[1] = ~ext[1];
    idle(2);
    wr(8'h0C, 32'h2);
    rd(8'h0C, v); chk(v, 32'h2, "R7 edge wins over clear");
    idle(2);
    @(negedge clk); wr(8'h0C, 32'h2);
    rd(8'h0C, v); chk(v, 0, "R7 later clear");

    // R8 interrupt sweep
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); wr(8'h0C, 32'hFFFF_FFFF);
      ext = ext ^ c[NL-1:0];
      idle(4);
      rd(8'h0C, v); chk(v, 32'(c), "R8 change pattern");
      for (int e = 0; e < 16; e++) begin
        @(negedge clk); wr(8'h08, 32'hFFFF_FFF0 | 32'(e));
        chk(32'(irq), 32'(((c & e) != 0) ? 1 : 0), "R8 irq");
      end
      rd(8'h08, v); chk(v, FULL, "R9 ien readback");
      @(negedge clk); wr(8'h08, 32'h0);
      chk(32'(irq), 0, "R8 irq masked");
    end

    // R4 masked data writes, outputs enabled
    @(negedge clk); wr(8'h00, FULL);
    outm = '0;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk); wr(8'h10, 32'hFFFF_FFF0 | 32'(m));
      rd(8'h10, v); chk(v, 32'(m), "R4 mask readback");
      for (int d = 0; d < 16; d++) begin
        @(negedge clk); wr(8'h04, 32'(d));
        outm = (outm & ~m[NL-1:0]) | (d[NL-1:0] & m[NL-1:0]);
        chk(32'(pad_out), 32'(outm), "R4 masked write");
      end
    end
    idle(3);
    rd(8'h04, v); chk(v, 32'(outm), "R2 driven level read");
    @(negedge clk); wr(8'h00, 32'h0);
    chk(32'(pad_oe), 0, "R2 released");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule